// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a slave serial port that lets an external controller load and inspect a bank of byte-wide configuration registers. The controller pulls the active-low enable pin low and clocks 24-bit words in on the serial data pin, sampled on rising serial-clock edges, most significant bit first. Each word holds two reserved bits, a 14-bit register address and a data byte. The controller may send any number of words back to back inside one enable window. Each whole word is committed as it completes. Leftover bits at the end of a window are dropped.

The serial pins are oversampled by the block's own system clock through two-flop synchronizers, so the port is edge-driven logic in a single clock domain. The serial clock must stay high for at least 3 system clocks and low for at least 6 system clocks. Under that limit any slower rate and any duty cycle work. Register 0 is the port's own control register. Its bit 1 turns on readout mode, in which the output driver is enabled and the addressed byte is shifted out on falling serial-clock edges. Its bit 0 is a software reset that restores every register to its default and then clears itself. The whole register bank is presented in parallel to the rest of the chip.

Top module: `spi_cfg_port`

## Requirements
- R1: After reset, register 0 holds 0x00, each register i from 1 to NUM_REGS-1 holds ((i*0x1D) XOR 0xA5) mod 256, and the output enable is low.
- R2: A 24-bit word, sent MSB first as {2 reserved bits, 14-bit address, 8-bit data}, writes its data byte to the addressed register once its 24th bit has been taken on a rising serial-clock edge. Register i appears on cfg_regs[8*i+7:8*i].
- R3: Several words sent within one enable-low window are each committed in order.
- R4: Bits past the last whole 24-bit word of a window are discarded. Raising the enable clears the bit count, so the next window starts a fresh word.
- R5: A word whose address is NUM_REGS or higher changes no register. The reserved bits have no effect.
- R6: The output enable is low whenever readout mode (register 0 bit 1) is clear, and high while it is set.
- R7: In readout mode, the byte held by the register addressed in the current word, or 0x00 if that address is out of range, is driven MSB first. Each bit is driven on the falling edge that follows rising edges 16 to 23 of the word, so the controller samples it on rising edges 17 to 24.
- R8: While readout mode is set, words addressed to any register other than register 0 do not write.
- R9: Writing a byte with bit 0 set to register 0 restores all registers to their R1 defaults, including register 0, so readout mode ends and bit 0 reads back as 0.
- R10: Results do not depend on serial-clock duty cycle or rate, given at least 3 system clocks high and 6 low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sen_n | input | 1 | Serial enable, active low |
| spi_sclk | input | 1 | Serial clock from the controller |
| spi_sdi | input | 1 | Serial data in |
| spi_sdo | output | 1 | Serial data out, meaningful while spi_sdo_oe is high |
| spi_sdo_oe | output | 1 | Output driver enable for the pad; low means high impedance |
| cfg_regs | output | 8*NUM_REGS | All configuration registers, register i at bits 8*i+7:8*i |

## Verification
On every cycle, the assertions check the following: the pad is disabled outside readout mode, and the register bank changes only one cycle after a word commit. A commit during readout mode that targets a non-control register leaves the bank untouched. A software reset lands exactly on the default vector. The bit count never passes 23 and returns to zero when the enable rises, and the output bit moves only after a falling serial edge. Only the bench's scenarios can show that the right byte lands in the right register, that the bytes read back are correct, and that trailing partial bits are dropped. They also show the behaviour under slow and lopsided serial clocks. The bench compares every output against its own register model.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int WORD_BITS = 24;
  localparam int RSV_BITS  = 2;
  localparam int ADDR_BITS = 14;
  localparam int DATA_BITS = 8;
  localparam int ADDR_END  = RSV_BITS + ADDR_BITS;
  localparam int CNT_W     = $clog2(WORD_BITS);
  localparam int SR_BITS   = WORD_BITS - RSV_BITS - 1;

  localparam int CTRL_RST_BIT  = 0;
  localparam int CTRL_READ_BIT = 1;

  function automatic logic [DATA_BITS-1:0] reg_default(input int idx);
    if (idx == 0) return '0;
    return DATA_BITS'((idx * 29) ^ 165);
  endfunction
endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic sen_n_in,
  input  logic sdi_in,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic active,
  output logic sdi_s
);
  logic [STAGES:0]   sclk_p;
  logic [STAGES-1:0] sen_p;
  logic [STAGES-1:0] sdi_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '0;
      sen_p  <= '1;
      sdi_p  <= '0;
    end else begin
      sclk_p <= {sclk_p[STAGES-1:0], sclk_in};
      sen_p  <= {sen_p[STAGES-2:0], sen_n_in};
      sdi_p  <= {sdi_p[STAGES-2:0], sdi_in};
    end
  end

  assign sclk_rise = sclk_p[STAGES-1] & ~sclk_p[STAGES];
  assign sclk_fall = ~sclk_p[STAGES-1] & sclk_p[STAGES];
  assign active    = ~sen_p[STAGES-1];
  assign sdi_s     = sdi_p[STAGES-1];
endmodule

// File: rtl/spi_cfg_shifter.sv
module spi_cfg_shifter
  import spi_cfg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rise,
  input  logic                 active,
  input  logic                 sdi,
  output logic [CNT_W-1:0]     bit_cnt,
  output logic                 commit,
  output logic [ADDR_BITS-1:0] wr_addr,
  output logic [DATA_BITS-1:0] wr_data,
  output logic                 addr_vld,
  output logic [ADDR_BITS-1:0] rd_addr
);
  logic [SR_BITS-1:0]   sr;
  logic [SR_BITS:0]     nxt;

  assign nxt = {sr, sdi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr       <= '0;
      bit_cnt  <= '0;
      commit   <= 1'b0;
      addr_vld <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      rd_addr  <= '0;
    end else begin
      commit   <= 1'b0;
      addr_vld <= 1'b0;
      if (!active) begin
        bit_cnt <= '0;
      end else if (rise) begin
        sr <= nxt[SR_BITS-1:0];
        if (bit_cnt == CNT_W'(WORD_BITS-1)) begin
          bit_cnt <= '0;
          commit  <= 1'b1;
          wr_addr <= nxt[DATA_BITS +: ADDR_BITS];
          wr_data <= nxt[DATA_BITS-1:0];
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
        if (bit_cnt == CNT_W'(ADDR_END-1)) begin
          addr_vld <= 1'b1;
          rd_addr  <= nxt[ADDR_BITS-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/spi_cfg_regfile.sv
module spi_cfg_regfile
  import spi_cfg_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         commit,
  input  logic [ADDR_BITS-1:0]         wr_addr,
  input  logic [DATA_BITS-1:0]         wr_data,
  input  logic [ADDR_BITS-1:0]         rd_addr,
  output logic [DATA_BITS-1:0]         rd_data,
  output logic                         readout,
  output logic [NUM_REGS*DATA_BITS-1:0] cfg_flat
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic soft_rst;
  logic wr_ok;

  assign readout  = cfg_flat[CTRL_READ_BIT];
  assign soft_rst = commit && (wr_addr == '0) && wr_data[CTRL_RST_BIT];
  assign wr_ok    = commit && (!readout || (wr_addr == '0));

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [DATA_BITS-1:0] DEF = reg_default(i);
    logic [DATA_BITS-1:0] r;
    logic                 hit;
    assign hit = wr_ok && (wr_addr == ADDR_BITS'(i));
    if (i == 0) begin : g_ctrl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        r <= DEF;
        else if (soft_rst) r <= DEF;
        else if (hit)      r <= DATA_BITS'(wr_data[CTRL_READ_BIT]) << CTRL_READ_BIT;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        r <= DEF;
        else if (soft_rst) r <= DEF;
        else if (hit)      r <= wr_data;
      end
    end
    assign cfg_flat[i*DATA_BITS +: DATA_BITS] = r;
  end

  logic             in_range;
  logic [IDX_W-1:0] rd_idx;
  assign in_range = rd_addr < ADDR_BITS'(NUM_REGS);
  assign rd_idx   = rd_addr[IDX_W-1:0];

  always_comb begin
    rd_data = '0;
    if (in_range) rd_data = cfg_flat[rd_idx*DATA_BITS +: DATA_BITS];
  end
endmodule

// File: rtl/spi_cfg_readout.sv
module spi_cfg_readout
  import spi_cfg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fall,
  input  logic                 active,
  input  logic                 readout,
  input  logic [CNT_W-1:0]     bit_cnt,
  input  logic                 load,
  input  logic [DATA_BITS-1:0] load_byte,
  output logic                 sdo,
  output logic                 sdo_oe
);
  logic [DATA_BITS-1:0] out_sr;

  assign sdo_oe = readout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_sr <= '0;
      sdo    <= 1'b0;
    end else if (load) begin
      out_sr <= load_byte;
    end else if (fall && active && readout && (bit_cnt >= CNT_W'(ADDR_END))) begin
      sdo    <= out_sr[DATA_BITS-1];
      out_sr <= out_sr << 1;
    end
  end
endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
  import spi_cfg_pkg::*;
#(
  parameter int NUM_REGS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          spi_sen_n,
  input  logic                          spi_sclk,
  input  logic                          spi_sdi,
  output logic                          spi_sdo,
  output logic                          spi_sdo_oe,
  output logic [NUM_REGS*DATA_BITS-1:0] cfg_regs
);
  logic                 sclk_rise, sclk_fall, active, sdi_s;
  logic [CNT_W-1:0]     bit_cnt;
  logic                 wr_commit, addr_vld, readout;
  logic [ADDR_BITS-1:0] wr_addr, rd_addr;
  logic [DATA_BITS-1:0] wr_data, rd_data;

  spi_cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .sclk_in(spi_sclk), .sen_n_in(spi_sen_n), .sdi_in(spi_sdi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .active(active), .sdi_s(sdi_s)
  );

  spi_cfg_shifter u_shift (
    .clk(clk), .rst_n(rst_n),
    .rise(sclk_rise), .active(active), .sdi(sdi_s),
    .bit_cnt(bit_cnt), .commit(wr_commit),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .addr_vld(addr_vld), .rd_addr(rd_addr)
  );

  spi_cfg_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .commit(wr_commit), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .readout(readout), .cfg_flat(cfg_regs)
  );

  spi_cfg_readout u_rd (
    .clk(clk), .rst_n(rst_n),
    .fall(sclk_fall), .active(active), .readout(readout),
    .bit_cnt(bit_cnt), .load(addr_vld), .load_byte(rd_data),
    .sdo(spi_sdo), .sdo_oe(spi_sdo_oe)
  );
endmodule

// File: rtl/spi_cfg_port_chk.sv
module spi_cfg_port_chk
  import spi_cfg_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_REGS*DATA_BITS-1:0] cfg_regs,
  input logic                          sdo,
  input logic                          sdo_oe,
  input logic                          sclk_fall,
  input logic                          active,
  input logic                          commit,
  input logic [ADDR_BITS-1:0]          wr_addr,
  input logic [DATA_BITS-1:0]          wr_data,
  input logic [CNT_W-1:0]              bit_cnt
);
  logic [NUM_REGS*DATA_BITS-1:0] def_vec;
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_def
    assign def_vec[i*DATA_BITS +: DATA_BITS] = reg_default(i);
  end

  // R6
  p_hiz_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_regs[CTRL_READ_BIT] |-> !sdo_oe);
  // R2
  p_change_needs_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_regs) |-> $past(commit));
  // R8
  p_readout_locks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && cfg_regs[CTRL_READ_BIT] && (wr_addr != '0)) |=> $stable(cfg_regs));
  // R9
  p_soft_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && (wr_addr == '0) && wr_data[CTRL_RST_BIT]) |=> (cfg_regs == def_vec));
  // R3
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt < CNT_W'(WORD_BITS));
  // R4
  p_idle_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (bit_cnt == '0));
  // R7
  p_sdo_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> $past(sclk_fall));
endmodule

bind spi_cfg_port spi_cfg_port_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_regs(cfg_regs),
  .sdo(spi_sdo), .sdo_oe(spi_sdo_oe), .sclk_fall(sclk_fall),
  .active(active), .commit(wr_commit), .wr_addr(wr_addr),
  .wr_data(wr_data), .bit_cnt(bit_cnt)
);

// File: tb/spi_cfg_port_test.sv
module spi_cfg_port_test;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sen_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic sdo, sdo_oe;
  logic [N*8-1:0] cfg;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [7:0]  mdl [N];
  logic [23:0] txw [8];
  logic [7:0]  rxb [8];
  logic [7:0]  expb [8];
  bit          expv [8];

  always #10 clk = ~clk;

  spi_cfg_port #(.NUM_REGS(N)) uut (
    .clk(clk), .rst_n(rst_n), .spi_sen_n(sen_n), .spi_sclk(sclk),
    .spi_sdi(sdi), .spi_sdo(sdo), .spi_sdo_oe(sdo_oe), .cfg_regs(cfg)
  );

  function automatic logic [7:0] dflt(input int i);
    if (i == 0) return 8'h00;
    return 8'((i * 8'h1D) ^ 8'hA5);
  endfunction

  function automatic logic [23:0] mk(input logic [1:0] rsv, input logic [13:0] a, input logic [7:0] d);
    return {rsv, a, d};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) mdl[i] = dflt(i);
  endtask

  task automatic model_word(input logic [23:0] w);
    logic [13:0] a;
    logic [7:0]  d;
    a = w[21:8];
    d = w[7:0];
    if (a == 0 && d[0]) model_reset();
    else if ((!mdl[0][1] || a == 0) && a < N) begin
      if (a == 0) mdl[0] = {6'b0, d[1], 1'b0};
      else mdl[a] = d;
    end
  endtask

  task automatic check_regs(input string tag);
    for (int i = 0; i < N; i++)
      chk(cfg[i*8 +: 8] == mdl[i], tag, {24'b0, cfg[i*8 +: 8]}, {24'b0, mdl[i]});
    chk(sdo_oe == mdl[0][1], {tag, " R6 oe"}, {31'b0, sdo_oe}, {31'b0, mdl[0][1]});
  endtask

  task automatic bit_cycle(input logic b, input int hi, input int lo, output logic got);
    sdi = b;
    repeat (lo) @(negedge clk);
    got = sdo;
    sclk = 1'b1;
    repeat (hi) @(negedge clk);
    sclk = 1'b0;
  endtask

  // sends nw words from txw plus extra trailing random bits, updates the model
  task automatic run_frame(input int nw, input int extra, input int hi, input int lo);
    logic g;
    @(negedge clk);
    sen_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < nw; k++) begin
      logic [13:0] a;
      a = txw[k][21:8];
      expv[k] = mdl[0][1];
      expb[k] = (a < N) ? mdl[a] : 8'h00;
      for (int b = 23; b >= 0; b--) begin
        bit_cycle(txw[k][b], hi, lo, g);
        if (b < 8) rxb[k][b] = g;
      end
      model_word(txw[k]);
    end
    for (int e = 0; e < extra; e++) bit_cycle(1'($urandom), hi, lo, g);
    repeat (lo) @(negedge clk);
    sen_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic check_reads(input int nw, input string tag);
    for (int k = 0; k < nw; k++)
      if (expv[k]) chk(rxb[k] == expb[k], tag, {24'b0, rxb[k]}, {24'b0, expb[k]});
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    void'($urandom(32'd2718));
    model_reset();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_regs("R1 reset defaults");

    // R2: random single writes
    for (int t = 0; t < 12; t++) begin
      txw[0] = mk(2'b00, 14'(1 + ($urandom % (N - 1))), 8'($urandom));
      run_frame(1, 0, 3, 6);
      check_regs("R2 single write");
    end

    // R3: back-to-back words in one window, same register hit twice
    txw[0] = mk(2'b00, 14'd3, 8'h11);
    txw[1] = mk(2'b00, 14'd7, 8'h22);
    txw[2] = mk(2'b00, 14'd3, 8'h33);
    run_frame(3, 0, 3, 6);
    check_regs("R3 multi word");

    // R4: trailing partial bits dropped, then aborted window
    txw[0] = mk(2'b00, 14'd9, 8'h5C);
    run_frame(1, 13, 3, 6);
    check_regs("R4 trailing bits");
    txw[0] = mk(2'b00, 14'd10, 8'hFF);
    run_frame(0, 10, 3, 6);
    txw[0] = mk(2'b00, 14'd11, 8'h6B);
    run_frame(1, 0, 3, 6);
    check_regs("R4 fresh word after abort");

    // R5: out of range addresses and reserved bits
    txw[0] = mk(2'b00, 14'h3FFF, 8'hEE);
    txw[1] = mk(2'b00, 14'(N), 8'hDD);
    txw[2] = mk(2'b11, 14'd4, 8'h4D);
    run_frame(3, 0, 3, 6);
    check_regs("R5 range and reserved");

    // R6/R7: enter readout mode, read back
    txw[0] = mk(2'b00, 14'd0, 8'h02);
    run_frame(1, 0, 3, 6);
    check_regs("R6 readout on");
    txw[0] = mk(2'b00, 14'd3, 8'h00);
    txw[1] = mk(2'b00, 14'd0, 8'h02);
    txw[2] = mk(2'b00, 14'h2000, 8'h00);
    txw[3] = mk(2'b00, 14'd11, 8'h00);
    run_frame(4, 0, 3, 6);
    check_reads(4, "R7 readback");
    for (int t = 0; t < 4; t++) begin
      txw[0] = mk(2'b00, 14'($urandom % (N + 4)), 8'h00);
      txw[1] = mk(2'b00, 14'($urandom % N), 8'h00);
      run_frame(2, 0, 3, 6);
      check_reads(2, "R7 random readback");
    end

    // R8: writes blocked in readout mode
    txw[0] = mk(2'b00, 14'd5, 8'hA9);
    txw[1] = mk(2'b00, 14'd5, 8'h00);
    run_frame(2, 0, 3, 6);
    check_regs("R8 write suppressed");
    check_reads(2, "R8 read after blocked write");

    // exit readout then scribble registers
    txw[0] = mk(2'b00, 14'd0, 8'h00);
    run_frame(1, 0, 3, 6);
    check_regs("R6 readout off");
    txw[0] = mk(2'b00, 14'd2, 8'h77);
    txw[1] = mk(2'b00, 14'd0, 8'h02);
    run_frame(2, 0, 3, 6);

    // R9: soft reset from readout mode
    txw[0] = mk(2'b00, 14'd0, 8'h03);
    run_frame(1, 0, 3, 6);
    check_regs("R9 soft reset");

    // R10: lopsided and slow serial clocks with readback
    for (int t = 0; t < 6; t++) begin
      int hi, lo;
      hi = (t % 3 == 0) ? 3 : ((t % 3 == 1) ? 14 : 40);
      lo = (t % 3 == 0) ? 11 : ((t % 3 == 1) ? 6 : 40);
      txw[0] = mk(2'($urandom), 14'(1 + ($urandom % (N - 1))), 8'($urandom));
      txw[1] = mk(2'b00, 14'd0, 8'h02);
      txw[2] = mk(2'b00, txw[0][21:8], 8'h00);
      txw[3] = mk(2'b00, 14'd0, 8'h00);
      run_frame(4, 0, hi, lo);
      check_regs("R10 timing variants");
      check_reads(4, "R10 readback timing");
    end

    finish_up();
  end
endmodule